// File: doc/BRIEF.md
# ADC Result Auto-Compare Unit

This block sits beside a sequenced analog-to-digital converter and post-processes its results. It holds eight result registers. Each register belongs to a position in the conversion sequence, not to an input channel. A sequence-start pulse arms the unit at position 0. Each result-valid strobe then delivers one 10-bit conversion and moves the unit to the next position. After the eighth result the sequence ends.

Software can turn on automatic comparison for each position. For an enabled position, software first writes a threshold into that position's result register and then sets an operator bit that picks the comparison direction. The arriving conversion is tested against the threshold and is never stored, so the threshold stays in place. The position's completion flag is set only when the test succeeds. A position with comparison turned off stores the result and always sets its flag. Any write to the compare-enable register aborts the sequence in progress and clears every flag.

Software reaches the registers over a simple word bus. The bus has a write strobe and byte addresses, and reads are combinational.

Top module: `adc_cmp_unit`

## Requirements
- R1: After reset, the compare-enable register (0x08), the status register (0x0A) and the operator register (0x0C) all read 0x0000, every result register reads 0x0000, and `seq_active` is low.
- R2: For a position whose compare-enable bit is 0, an accepted result is stored zero-extended in that position's result register, and the position's status bit (status bit n for position n) becomes 1.
- R3: For a compare-enabled position with operator bit 1, the status bit becomes 1 only when the result is strictly greater than the 16-bit register value. The register keeps the threshold.
- R4: For a compare-enabled position with operator bit 0, the status bit becomes 1 only when the result is less than or equal to the threshold. The register keeps the threshold.
- R5: The k-th accepted result after a start (k = 0..7) goes to position k, and at most one status bit rises per cycle. After the eighth result `seq_active` goes low, and later strobes change nothing until the next start.
- R6: Any bus write to 0x08 loads the enable bits from wdata[7:0], drops `seq_active`, and clears all status bits in the following cycle. Strobes after the abort are ignored.
- R7: `seq_start` raises `seq_active`, clears all status bits and restarts at position 0, including in the middle of a sequence. A strobe in the same cycle as a start is ignored, and a write to 0x08 wins over a start in the same cycle.
- R8: Writes to the status register at 0x0A have no effect. Bits 15:8 of the enable, status and operator registers always read 0.
- R9: The result register for position n sits at byte offset 0x10 + 2n. Each result register can be read and written as 16 bits, and the operator register at 0x0C reads back what was written to bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register; bit 0 is ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| seq_start | input | 1 | Begin a new sequence at position 0 |
| res_valid | input | 1 | One conversion result is presented |
| res_data | input | 10 | Conversion result, right-aligned |
| seq_active | output | 1 | A sequence is accepting results |

## Verification
If the position counter goes wrong, the next result and its flag land in the wrong register. The error can be read over the bus one cycle after that strobe. If an enable or operator bit is corrupted, the flag takes the wrong sense, or a threshold is overwritten with the raw result, on the first conversion at that position. The random sequences aim results at exactly the threshold and at one code either side of it, so an off-by-one in the comparison shows up within a few sequences. A missed abort or restart leaves stale flags or keeps `seq_active` high, and this is visible in the cycle right after the write or start.

// File: rtl/adc_cmp_unit.sv
module adc_cmp_unit #(
  parameter int NSLOT = 8,
  parameter int RES_W = 10,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          seq_start,
  input  logic          res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic          seq_active
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [AW-2:0] IDX_EN   = (AW-1)'(4);
  localparam logic [AW-2:0] IDX_STAT = (AW-1)'(5);
  localparam logic [AW-2:0] IDX_OP   = (AW-1)'(6);

  logic [DW-1:0]    res_q [NSLOT];
  logic [NSLOT-1:0] en_q, op_q, flag_q;
  logic             act_q;
  logic [SW-1:0]    slot_q;

  wire [AW-2:0] widx   = bus_addr[AW-1:1];
  wire          en_wr  = bus_wr && widx == IDX_EN;
  wire          op_wr  = bus_wr && widx == IDX_OP;
  wire          res_wr = bus_wr && bus_addr[AW-1];
  wire [SW-1:0] wslot  = bus_addr[SW:1];
  wire          take   = res_valid && act_q && !en_wr && !seq_start;
  wire [DW-1:0] rext   = DW'(res_data);
  wire [DW-1:0] thr    = res_q[slot_q];
  wire          hit    = op_q[slot_q] ? (rext > thr) : (rext <= thr);
  wire          last   = slot_q == SW'(NSLOT-1);

  assign seq_active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      op_q   <= '0;
      flag_q <= '0;
      act_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      if (op_wr) op_q <= bus_wdata[NSLOT-1:0];
      if (en_wr) begin
        en_q   <= bus_wdata[NSLOT-1:0];
        act_q  <= 1'b0;
        flag_q <= '0;
      end else if (seq_start) begin
        act_q  <= 1'b1;
        slot_q <= '0;
        flag_q <= '0;
      end else if (take) begin
        if (!en_q[slot_q] || hit) flag_q[slot_q] <= 1'b1;
        slot_q <= slot_q + 1'b1;
        if (last) act_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        res_q[i] <= '0;
      else if (res_wr && wslot == SW'(i))
        res_q[i] <= bus_wdata;
      else if (take && slot_q == SW'(i) && !en_q[i])
        res_q[i] <= rext;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1])
      bus_rdata = res_q[wslot];
    else if (widx == IDX_EN)
      bus_rdata[NSLOT-1:0] = en_q;
    else if (widx == IDX_STAT)
      bus_rdata[NSLOT-1:0] = flag_q;
    else if (widx == IDX_OP)
      bus_rdata[NSLOT-1:0] = op_q;
  end

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (!act_q && flag_q == '0));

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !en_wr) |=> (act_q && slot_q == '0 && flag_q == '0));

  assert_flag_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) != '0) |-> $past(res_valid && act_q));

  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag_q & ~$past(flag_q)) <= 1);

  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> !act_q);

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !seq_start) |=> (!act_q && $stable(flag_q) || $past(en_wr)));
endmodule

// File: tb/sim_adc_cmp_unit.sv
module sim_adc_cmp_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        seq_start = 0;
  logic        res_valid = 0;
  logic [9:0]  res_data = 0;
  logic        seq_active;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] m_res [8];
  logic [7:0]  m_en = 0, m_op = 0, m_flag = 0;
  bit          m_act = 0;
  int          m_slot = 0;

  always #5 clk = ~clk;

  adc_cmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_start(seq_start),
    .res_valid(res_valid), .res_data(res_data), .seq_active(seq_active));

  function automatic bit cmp_hit(bit op, logic [15:0] thr, logic [9:0] r);
    return op ? ({6'b0, r} > thr) : ({6'b0, r} <= thr);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic bwr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a[4]) m_res[a[3:1]] = d;
    else if (a[4:1] == 4'd4) begin m_en = d[7:0]; m_act = 0; m_flag = 0; end
    else if (a[4:1] == 4'd6) m_op = d[7:0];
  endtask

  task automatic start();
    @(negedge clk);
    seq_start = 1;
    @(negedge clk);
    seq_start = 0;
    m_act = 1; m_slot = 0; m_flag = 0;
  endtask

  task automatic conv(logic [9:0] d);
    @(negedge clk);
    res_valid = 1; res_data = d;
    @(negedge clk);
    res_valid = 0;
    if (m_act) begin
      if (m_en[m_slot]) begin
        if (cmp_hit(m_op[m_slot], m_res[m_slot], d)) m_flag[m_slot] = 1;
      end else begin
        m_res[m_slot] = {6'b0, d};
        m_flag[m_slot] = 1;
      end
      m_slot++;
      if (m_slot == 8) begin m_act = 0; m_slot = 0; end
    end
  endtask

  task automatic chk_all(string ctx);
    rd(5'h0A, {8'h0, m_flag}, {ctx, " R2 R3 R4 status"});
    for (int i = 0; i < 8; i++) begin
      string t;
      t = !m_en[i] ? "R2" : (m_op[i] ? "R3" : "R4");
      rd(5'(16 + 2 * i), m_res[i], $sformatf("%s %s result slot %0d", ctx, t, i));
    end
    check({ctx, " R5 seq_active"}, {15'b0, seq_active}, {15'b0, m_act});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] thr [8];
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_res[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(5'h08, 16'h0, "R1 enable");
    rd(5'h0A, 16'h0, "R1 status");
    rd(5'h0C, 16'h0, "R1 operator");
    check("R1 seq_active", {15'b0, seq_active}, 16'h0);
    chk_all("R1");

    // R9 operator register and result offsets
    bwr(5'h0C, 16'hFFA5);
    rd(5'h0C, 16'h00A5, "R9 R8 operator readback");
    bwr(5'h16, 16'hBEEF);
    rd(5'h16, 16'hBEEF, "R9 result slot 3 offset");
    bwr(5'h08, 16'hFF00);
    rd(5'h08, 16'h0000, "R8 enable upper bits");

    // plain sequence, R2 and R5
    start();
    for (int k = 0; k < 8; k++) conv(10'(k * 100 + 7));
    chk_all("plain");
    conv(10'h3FF);
    chk_all("R5 extra strobe ignored");

    // R8 status write has no effect
    bwr(5'h0A, 16'h0000);
    rd(5'h0A, {8'h0, m_flag}, "R8 status write ignored");

    // random sequences with compare
    for (int s = 0; s < 30; s++) begin
      for (int i = 0; i < 8; i++) begin
        thr[i] = 10'($urandom);
        bwr(5'(16 + 2 * i), {6'b0, thr[i]});
      end
      bwr(5'h0C, 16'($urandom & 8'hFF));
      bwr(5'h08, 16'($urandom & 8'hFF));
      start();
      for (int k = 0; k < 8; k++) begin
        logic [9:0] r;
        case ($urandom % 4)
          0: r = thr[k];
          1: r = thr[k] + 10'd1;
          2: r = thr[k] - 10'd1;
          default: r = 10'($urandom);
        endcase
        conv(r);
      end
      chk_all($sformatf("rand%0d", s));
    end

    // R6 abort mid-sequence
    bwr(5'h08, 16'h0000);
    start();
    conv(10'd11); conv(10'd22); conv(10'd33);
    rd(5'h0A, 16'h0007, "R6 flags before abort");
    bwr(5'h08, 16'h0010);
    rd(5'h0A, 16'h0000, "R6 flags cleared");
    check("R6 seq_active low", {15'b0, seq_active}, 16'h0);
    conv(10'd44);
    chk_all("R6 strobe after abort");

    // R7 restart mid-sequence
    bwr(5'h08, 16'h0000);
    start();
    conv(10'd1); conv(10'd2); conv(10'd3); conv(10'd4);
    start();
    rd(5'h0A, 16'h0000, "R7 flags cleared on restart");
    check("R7 seq_active", {15'b0, seq_active}, 16'h1);
    conv(10'd500);
    rd(5'h10, 16'd500, "R7 restart at slot 0");
    rd(5'h0A, 16'h0001, "R7 status after first result");
    chk_all("R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule